// File: doc/BRIEF.md
# Two-Bank FM Synthesizer Register Write Port

This block sits between a byte-wide host bus and the register file of an FM synthesizer whose port space is 512 bytes, split into two banks of 256. The host sees three byte registers at consecutive offsets. Offset +0 selects a port in bank 0, offset +2 selects a port in bank 1, and offset +1 carries the data byte for either bank. An address write only latches a 9-bit port number. A data write commits the byte to that port and produces a one-clock write strobe towards the register file. The latched port stays in place, so a run of data writes all land on the same port.

While committing, the block snoops two control ports of bank 1. Port 0x105 bit 0 enables the extended mode: 36 operators, four-operator voices, eight waveforms and stereo. When that bit is clear the synthesizer runs as its 18-operator compatible subset. Port 0x104 bits 5:0 pair channel groups into four-operator voices, and the block exports these bits. A combinational lookup gives the port offset of an operator from its bank, its channel (0 to 8) and its role as modulator or carrier. The offsets follow a non-linear layout of three channels per group of eight slots.

Top module: `fm_regif`

## Requirements
- R1: A host write at offset +0 (host_sel = 0) latches port {0, byte}; the next data write commits to that bank-0 port.
- R2: A host write at offset +2 (host_sel = 2) latches port {1, byte}; the next data write commits to that bank-1 port.
- R3: A host write at offset +1 (host_sel = 1) raises rf_we for exactly the clock after the write edge, with rf_wdata equal to the written byte. Address writes never raise rf_we.
- R4: A data write made before any address write since reset commits to port 0x000.
- R5: The latched port persists across data writes. The most recent address write, from either bank register, decides the target.
- R6: A host write at offset +3 (host_sel = 3) changes neither the latched port nor the mode outputs, and raises no strobe.
- R7: ext_mode follows bit 0 of the latest byte committed to port 0x105. It ignores the other bits, and a commit to bank-0 port 0x005 leaves it unchanged.
- R8: The six bits committed to port 0x104 (bit 0: channels 0-3, bit 1: 1-4, bit 2: 2-5, bit 3: 9-12, bit 4: 10-13, bit 5: 11-14) are stored. pair_en shows them only while ext_mode is 1 and is zero otherwise.
- R9: For lk_chan c in 0..8, lk_slot = lk_bank*256 + (c/3)*8 + (c mod 3) + 3*lk_carrier, with lk_valid = 1. This gives modulators 0x00,0x01,0x02,0x08,0x09,0x0A,0x10,0x11,0x12 and their carriers at +3.
- R10: For lk_chan above 8, lk_valid = 0 and lk_slot = 0.
- R11: After reset, rf_we, rf_addr, ext_mode and pair_en are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write enable, one cycle per access |
| host_sel | input | 2 | Host register offset: 0 bank-0 address, 1 data, 2 bank-1 address, 3 unused |
| host_wdata | input | 8 | Host write byte |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | 9 | Register-file port number |
| rf_wdata | output | 8 | Register-file write byte |
| ext_mode | output | 1 | Extended (36-operator) mode enable |
| pair_en | output | 6 | Four-operator pairing bits, gated by ext_mode |
| lk_bank | input | 1 | Lookup bank |
| lk_chan | input | 4 | Lookup channel, 0 to 8 within the bank |
| lk_carrier | input | 1 | Lookup role: 1 carrier, 0 modulator |
| lk_slot | output | 9 | Port offset of the operator, bank in bit 8 |
| lk_valid | output | 1 | Lookup channel is in range |

## Verification
Some behaviour is checked by the assertions on every clock. They check the one-clock strobe and its data byte, the commit address after an address write followed by a data write in either bank, and that the mode outputs change only after a data write. They also check that pairing is never visible without the extended mode, and that out-of-range lookups give zero. Other behaviour needs the bench's scenarios, because it depends on longer histories. These are the default port after reset, persistence across repeated data writes, the dead fourth offset, which data bits the mode ports store, and the full offset table for both banks.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
   // Host register offsets; the bank-1 address sits at +2 by design.
   typedef enum logic [1:0] {
      HR_ADDR_LO = 2'd0,
      HR_DATA    = 2'd1,
      HR_ADDR_HI = 2'd2,
      HR_SPARE   = 2'd3
   } host_reg_e;
endpackage

// File: rtl/fmr_addr_latch.sv
module fmr_addr_latch
   import fmr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  host_reg_e         sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] addr
);
   localparam int LOW_W = ADDR_W - 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (we) begin
         case (sel)
            HR_ADDR_LO: addr <= {1'b0, LOW_W'(wdata)};
            HR_ADDR_HI: addr <= {1'b1, LOW_W'(wdata)};
            default:    addr <= addr;
         endcase
      end
   end
endmodule

// File: rtl/fmr_commit.sv
module fmr_commit #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 9,
   parameter bit REG_STROBE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata
);
   generate
      if (REG_STROBE) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rf_we    <= 1'b0;
               rf_addr  <= '0;
               rf_wdata <= '0;
            end else begin
               rf_we <= commit;
               if (commit) begin
                  rf_addr  <= addr;
                  rf_wdata <= wdata;
               end
            end
         end
      end else begin : g_comb
         always_comb begin
            rf_we    = commit & rst_n;
            rf_addr  = addr;
            rf_wdata = wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/fmr_mode_regs.sv
module fmr_mode_regs #(
   parameter int              ADDR_W    = 9,
   parameter int              PAIR_BITS = 6,
   parameter logic [ADDR_W-1:0] EXT_PORT  = 9'h105,
   parameter logic [ADDR_W-1:0] PAIR_PORT = 9'h104
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 commit,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [PAIR_BITS-1:0] wdata,
   output logic                 ext_mode,
   output logic [PAIR_BITS-1:0] pair_en
);
   logic                 ext_q;
   logic [PAIR_BITS-1:0] pair_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ext_q  <= 1'b0;
         pair_q <= '0;
      end else if (commit) begin
         if (addr == EXT_PORT)  ext_q  <= wdata[0];
         if (addr == PAIR_PORT) pair_q <= wdata;
      end
   end

   // Pairing only takes effect in the extended mode; storage is kept raw.
   always_comb begin
      ext_mode = ext_q;
      pair_en  = ext_q ? pair_q : '0;
   end
endmodule

// File: rtl/fmr_slot_map.sv
module fmr_slot_map #(
   parameter int NUM_CH       = 9,
   parameter int GROUP        = 3,
   parameter int STRIDE       = 8,
   parameter int CARRIER_STEP = 3,
   parameter int ADDR_W       = 9,
   parameter int CH_W         = 4
) (
   input  logic              bank,
   input  logic [CH_W-1:0]   chan,
   input  logic              carrier,
   output logic [ADDR_W-1:0] slot,
   output logic              valid
);
   localparam int OFF_W = ADDR_W - 1;

   logic [OFF_W-1:0] mod_off [NUM_CH];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_tbl
         localparam int OFF = (i / GROUP) * STRIDE + (i % GROUP);
         assign mod_off[i] = OFF_W'(OFF);
      end
   endgenerate

   logic [OFF_W-1:0] sel_off;

   always_comb begin
      sel_off = '0;
      valid   = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (chan == CH_W'(i)) begin
            sel_off = mod_off[i];
            valid   = 1'b1;
         end
      end
      if (valid) begin
         slot = {bank, sel_off + (carrier ? OFF_W'(CARRIER_STEP) : '0)};
      end else begin
         slot = '0;
      end
   end
endmodule

// File: rtl/fm_regif.sv
module fm_regif
   import fmr_pkg::*;
#(
   parameter int              DATA_W       = 8,
   parameter int              ADDR_W       = 9,
   parameter int              PAIR_BITS    = 6,
   parameter int              NUM_CH       = 9,
   parameter int              GROUP        = 3,
   parameter int              STRIDE       = 8,
   parameter int              CARRIER_STEP = 3,
   parameter bit              REG_STROBE   = 1'b1,
   parameter logic [8:0]      EXT_PORT     = 9'h105,
   parameter logic [8:0]      PAIR_PORT    = 9'h104,
   localparam int             CH_W         = $clog2(NUM_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic [1:0]           host_sel,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic                 rf_we,
   output logic [ADDR_W-1:0]    rf_addr,
   output logic [DATA_W-1:0]    rf_wdata,
   output logic                 ext_mode,
   output logic [PAIR_BITS-1:0] pair_en,
   input  logic                 lk_bank,
   input  logic [CH_W-1:0]      lk_chan,
   input  logic                 lk_carrier,
   output logic [ADDR_W-1:0]    lk_slot,
   output logic                 lk_valid
);
   // Elaboration-time parameter checks.
   generate
      if (ADDR_W != DATA_W + 1) begin : g_bad_addr_w
         $error("fm_regif: ADDR_W must be DATA_W + 1 (two banks)");
      end
      if (PAIR_BITS > DATA_W) begin : g_bad_pair
         $error("fm_regif: PAIR_BITS must fit in one data byte");
      end
      if (ADDR_W != 9) begin : g_bad_ports
         $error("fm_regif: control port constants assume a 9-bit port space");
      end
      if ((NUM_CH - 1) / GROUP * STRIDE + GROUP - 1 + CARRIER_STEP >= 2 ** DATA_W) begin : g_bad_map
         $error("fm_regif: operator map overflows a bank");
      end
   endgenerate

   host_reg_e         sel;
   logic              commit;
   logic [ADDR_W-1:0] cur_addr;

   assign sel    = host_reg_e'(host_sel);
   assign commit = host_we && (sel == HR_DATA);

   fmr_addr_latch #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (host_we),
      .sel   (sel),
      .wdata (host_wdata),
      .addr  (cur_addr)
   );

   fmr_commit #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .REG_STROBE (REG_STROBE)
   ) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .addr     (cur_addr),
      .wdata    (host_wdata),
      .rf_we    (rf_we),
      .rf_addr  (rf_addr),
      .rf_wdata (rf_wdata)
   );

   fmr_mode_regs #(
      .ADDR_W    (ADDR_W),
      .PAIR_BITS (PAIR_BITS),
      .EXT_PORT  (EXT_PORT),
      .PAIR_PORT (PAIR_PORT)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .addr     (cur_addr),
      .wdata    (host_wdata[PAIR_BITS-1:0]),
      .ext_mode (ext_mode),
      .pair_en  (pair_en)
   );

   fmr_slot_map #(
      .NUM_CH       (NUM_CH),
      .GROUP        (GROUP),
      .STRIDE       (STRIDE),
      .CARRIER_STEP (CARRIER_STEP),
      .ADDR_W       (ADDR_W),
      .CH_W         (CH_W)
   ) u_map (
      .bank    (lk_bank),
      .chan    (lk_chan),
      .carrier (lk_carrier),
      .slot    (lk_slot),
      .valid   (lk_valid)
   );
endmodule

// File: rtl/fm_regif_chk.sv
module fm_regif_chk #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 9,
   parameter int PAIR_BITS  = 6,
   parameter int CH_W       = 4,
   parameter bit REG_STROBE = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 host_we,
   input logic [1:0]           host_sel,
   input logic [DATA_W-1:0]    host_wdata,
   input logic                 rf_we,
   input logic [ADDR_W-1:0]    rf_addr,
   input logic [DATA_W-1:0]    rf_wdata,
   input logic                 ext_mode,
   input logic [PAIR_BITS-1:0] pair_en,
   input logic                 lk_bank,
   input logic [CH_W-1:0]      lk_chan,
   input logic                 lk_carrier,
   input logic [ADDR_W-1:0]    lk_slot,
   input logic                 lk_valid
);
   localparam int LOW_W = ADDR_W - 1;

   generate
      if (REG_STROBE) begin : g_reg_checks
         assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (host_we && host_sel == 2'd1) |=> (rf_we && rf_wdata == $past(host_wdata)));

         assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(host_we && host_sel == 2'd1) |=> !rf_we);

         assert_bank0_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(host_we && host_sel == 2'd0) && host_we && host_sel == 2'd1)
            |=> (rf_addr == {1'b0, LOW_W'($past(host_wdata, 2))}));

         assert_bank1_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(host_we && host_sel == 2'd2) && host_we && host_sel == 2'd1)
            |=> (rf_addr == {1'b1, LOW_W'($past(host_wdata, 2))}));
      end
   endgenerate

   assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(host_we && host_sel == 2'd1) |-> ($stable(ext_mode) && $stable(pair_en)));

   assert_pair_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en != '0) |-> ext_mode);

   assert_lookup_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> (lk_slot[ADDR_W-1] == lk_bank && lk_slot[2:0] <= 3'd5 && lk_chan <= CH_W'(8)
                    && (lk_carrier || lk_slot[2:0] <= 3'd2)));

   assert_lookup_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (lk_slot == '0));
endmodule

bind fm_regif fm_regif_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .PAIR_BITS  (PAIR_BITS),
   .CH_W       (CH_W),
   .REG_STROBE (REG_STROBE)
) u_chk (.*);

// File: tb/tb_fm_regif.sv
module tb_fm_regif;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [1:0] host_sel = 2'd0;
   logic [7:0] host_wdata = 8'h00;
   logic       rf_we;
   logic [8:0] rf_addr;
   logic [7:0] rf_wdata;
   logic       ext_mode;
   logic [5:0] pair_en;
   logic       lk_bank = 1'b0;
   logic [3:0] lk_chan = 4'd0;
   logic       lk_carrier = 1'b0;
   logic [8:0] lk_slot;
   logic       lk_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fm_regif dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .rf_we(rf_we), .rf_addr(rf_addr),
      .rf_wdata(rf_wdata), .ext_mode(ext_mode), .pair_en(pair_en),
      .lk_bank(lk_bank), .lk_chan(lk_chan), .lk_carrier(lk_carrier),
      .lk_slot(lk_slot), .lk_valid(lk_valid)
   );

   // Vector: {sel, byte, strobe expected, port expected, data expected}
   localparam logic [27:0] VEC [10] = '{
      {2'd0, 8'h20, 1'b0, 9'h000, 8'h00},
      {2'd1, 8'h21, 1'b1, 9'h020, 8'h21},
      {2'd1, 8'h7E, 1'b1, 9'h020, 8'h7E},
      {2'd2, 8'h43, 1'b0, 9'h000, 8'h00},
      {2'd1, 8'h55, 1'b1, 9'h143, 8'h55},
      {2'd0, 8'hB0, 1'b0, 9'h000, 8'h00},
      {2'd1, 8'h2A, 1'b1, 9'h0B0, 8'h2A},
      {2'd2, 8'hFF, 1'b0, 9'h000, 8'h00},
      {2'd1, 8'h00, 1'b1, 9'h1FF, 8'h00},
      {2'd0, 8'h00, 1'b0, 9'h000, 8'h00}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // One host access; returns at the negedge after the capturing edge.
   task automatic host_write(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      host_we    = 1'b1;
      host_sel   = s;
      host_wdata = d;
      @(negedge clk);
      host_we    = 1'b0;
   endtask

   task automatic expect_commit(input string req, input logic [8:0] a, input logic [7:0] d);
      check(rf_we == 1'b1, req, "strobe", int'(rf_we), 1);
      check(rf_addr == a, req, "port", int'(rf_addr), int'(a));
      check(rf_wdata == d, req, "data", int'(rf_wdata), int'(d));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog R3: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check(rf_we == 1'b0, "R11", "rf_we", int'(rf_we), 0);
      check(rf_addr == 9'h000, "R11", "rf_addr", int'(rf_addr), 0);
      check(ext_mode == 1'b0, "R11", "ext_mode", int'(ext_mode), 0);
      check(pair_en == 6'h00, "R11", "pair_en", int'(pair_en), 0);

      // R4 default port
      host_write(2'd1, 8'hA5);
      expect_commit("R4", 9'h000, 8'hA5);
      @(negedge clk);
      check(rf_we == 1'b0, "R3", "strobe one clock", int'(rf_we), 0);

      // Vector table: R1, R2, R3, R5
      for (int i = 0; i < 10; i++) begin
         host_write(VEC[i][27:26], VEC[i][25:18]);
         if (VEC[i][17]) begin
            expect_commit("R1/R2/R5", VEC[i][16:8], VEC[i][7:0]);
         end else begin
            check(rf_we == 1'b0, "R3", "no strobe on address write", int'(rf_we), 0);
         end
      end

      // R6 dead offset
      host_write(2'd0, 8'h20);
      host_write(2'd3, 8'h99);
      check(rf_we == 1'b0, "R6", "strobe on offset 3", int'(rf_we), 0);
      host_write(2'd1, 8'h11);
      expect_commit("R6", 9'h020, 8'h11);
      check(ext_mode == 1'b0, "R6", "ext_mode", int'(ext_mode), 0);

      // R8 pairing hidden without extended mode
      host_write(2'd2, 8'h04);
      host_write(2'd1, 8'h3F);
      check(pair_en == 6'h00, "R8", "pair_en masked", int'(pair_en), 0);
      // R7 bank-0 alias does not enable
      host_write(2'd0, 8'h05);
      host_write(2'd1, 8'h01);
      check(ext_mode == 1'b0, "R7", "bank0 port 0x005", int'(ext_mode), 0);
      // R7 only bit 0 counts
      host_write(2'd2, 8'h05);
      host_write(2'd1, 8'hFE);
      check(ext_mode == 1'b0, "R7", "bit0 clear", int'(ext_mode), 0);
      host_write(2'd1, 8'h01);
      check(ext_mode == 1'b1, "R7", "enable", int'(ext_mode), 1);
      check(pair_en == 6'h3F, "R8", "stored pairing shown", int'(pair_en), 'h3F);
      host_write(2'd2, 8'h04);
      host_write(2'd1, 8'h05);
      check(pair_en == 6'h05, "R8", "pairing update", int'(pair_en), 'h05);
      host_write(2'd2, 8'h05);
      host_write(2'd1, 8'h00);
      check(ext_mode == 1'b0, "R7", "disable", int'(ext_mode), 0);
      check(pair_en == 6'h00, "R8", "masked again", int'(pair_en), 0);

      // R9 operator offset lookup
      for (int b = 0; b < 2; b++) begin
         for (int c = 0; c < 9; c++) begin
            for (int r = 0; r < 2; r++) begin
               lk_bank    = 1'(b);
               lk_chan    = 4'(c);
               lk_carrier = 1'(r);
               #1;
               check(lk_valid == 1'b1, "R9", "valid", int'(lk_valid), 1);
               check(lk_slot == 9'(b * 256 + (c / 3) * 8 + (c % 3) + 3 * r),
                     "R9", "slot", int'(lk_slot), b * 256 + (c / 3) * 8 + (c % 3) + 3 * r);
            end
         end
      end
      lk_bank = 1'b1; lk_chan = 4'd8; lk_carrier = 1'b1; #1;
      check(lk_slot == 9'h115, "R9", "bank1 ch8 carrier", int'(lk_slot), 'h115);

      // R10 out-of-range channel
      lk_chan = 4'd9; #1;
      check(lk_valid == 1'b0 && lk_slot == 9'h000, "R10", "chan 9", int'(lk_slot), 0);
      lk_chan = 4'd15; #1;
      check(lk_valid == 1'b0 && lk_slot == 9'h000, "R10", "chan 15", int'(lk_slot), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule